// File: doc/BRIEF.md
# Instruction Field Decoder and Effective-Address Former

This block accepts a fetched 16-bit instruction of a word-addressed machine and resolves it into its fields and its effective address. The leading word is sliced into an operation code, a format bit, a tag and an 8-bit low field. The low field is read in one of two ways. In the one-word form it is a signed displacement. In the two-word form it holds indirect, branch-out and condition-select bits. The effective address is formed from a base register picked by the tag, from the second word, or from memory when one level of indirection applies.

A controller pulses `start` with both instruction words, the already-advanced instruction counter and the three index registers on the inputs. For direct addressing the address and a `done` strobe follow one clock later. For indirect addressing the block raises a read request, waits for the acknowledge, and takes the returned word as the effective address. Operation codes outside the defined set are reported by a single-cycle flag, and no address is produced for them.

Top module: `idec_top`

## Requirements
- R1: On an accepted `start`, the outputs take these fields of `instr_w0` (bit 15 is the most significant bit): op_code = [15:11], fmt_long = [10], tag = [9:8], disp = [7:0], ind_flag = [7], bo_flag = [6], cond_sel = [5:0]. They hold until the next accepted `start`.
- R2: When fmt_long is 0, the effective address is base + sign-extended disp, modulo 65536. The base is `ic_next` for tag 0 and `xr1`, `xr2`, `xr3` for tags 1, 2 and 3.
- R3: When fmt_long is 1, the pre-indirection address is `instr_w1` plus the index register picked by the tag, modulo 65536. Tag 0 adds nothing.
- R4: A valid direct instruction makes `done` high for exactly the one cycle after the accepting edge, with `ea` valid there, and `rd_req` stays low.
- R5: A valid two-word instruction with bit 7 set is indirect. `rd_req` rises one cycle after the accepting edge, with `rd_addr` equal to the R3 address. Both are held until `rd_ack` is sampled high. On the following cycle `ea` equals the `rd_data` sampled with the acknowledge, `done` is high for one cycle and `rd_req` is low.
- R6: For op_code 14 (the index-modify-and-skip operation) with tag 0, bit 7 is not an indirect flag, and the instruction completes as direct.
- R7: Op_codes 0, 7, 10, 11, 15 and 31 are invalid. For these, `bad_op` is high for exactly the one cycle after the accepting edge, and neither `done` nor `rd_req` is raised.
- R8: A `start` while an indirect read is pending is ignored: the decoded fields and `rd_addr` do not change.
- R9: After reset, `done`, `bad_op` and `rd_req` are 0 and `ea` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Present a new instruction (accepted only when no read is pending) |
| instr_w0 | input | 16 | Leading instruction word |
| instr_w1 | input | 16 | Second (address) word, used in the two-word form |
| ic_next | input | 16 | Instruction counter already advanced past the instruction |
| xr1 | input | 16 | Index register 1 |
| xr2 | input | 16 | Index register 2 |
| xr3 | input | 16 | Index register 3 |
| rd_ack | input | 1 | Memory read acknowledge |
| rd_data | input | 16 | Memory read data, valid with rd_ack |
| op_code | output | 5 | Decoded operation code |
| fmt_long | output | 1 | Format bit (1 = two-word form) |
| tag | output | 2 | Base/index selector |
| disp | output | 8 | Low field, the signed displacement in the one-word form |
| ind_flag | output | 1 | Indirect bit of the low field |
| bo_flag | output | 1 | Branch-out bit of the low field |
| cond_sel | output | 6 | Condition-select bits of the low field |
| ea | output | 16 | Effective address |
| done | output | 1 | One-cycle strobe, ea valid |
| bad_op | output | 1 | One-cycle invalid-operation strobe |
| rd_req | output | 1 | Indirect read request |
| rd_addr | output | 16 | Indirect read address |

## Verification
Every cycle, the assertions check the handshake rules. A pending request keeps its address until acknowledged. An acknowledge is followed by `done` with `ea` equal to the data returned. A strobe appears only after an accepted start or an acknowledge. `bad_op` never coincides with `done` or a request. A start that arrives during a pending read leaves the fields untouched. Whether the address arithmetic is right can only be seen in the bench scenarios: sign extension of the displacement, choice of base by tag, index addition and wrap past 65535. The same holds for the invalid-code set and the exception for operation 14 with tag 0. The bench compares these against its own model of the encodings.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int WORD_W = 16;
  localparam int OP_W   = 5;
  localparam int TAG_W  = 2;
  localparam int LOW_W  = 8;
  localparam int COND_W = 6;

  typedef logic [WORD_W-1:0] word_t;

  // Leading word viewed as fields; the first member lands in the top bits.
  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic             fmt;
    logic [TAG_W-1:0] tag;
    logic [LOW_W-1:0] low;
  } ifields_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} seq_st_t;

  function automatic word_t sext_low(input logic [LOW_W-1:0] d);
    return {{(WORD_W-LOW_W){d[LOW_W-1]}}, d};
  endfunction

  function automatic word_t wrap_add(input word_t a, input word_t b);
    return a + b;
  endfunction
endpackage

// File: rtl/idec_fields.sv
module idec_fields
  import idec_pkg::*;
#(
  parameter logic [31:0]     VALID_MASK = 32'h7FFF_737E,
  parameter logic [OP_W-1:0] SKIP_OP    = 5'd14
) (
  input  word_t              w0,
  output ifields_t           f,
  output logic               ind,
  output logic               bo,
  output logic [COND_W-1:0]  cond,
  output logic               op_ok,
  output logic               ind_eff
);
  localparam int IND_BIT = LOW_W - 1;
  localparam int BO_BIT  = LOW_W - 2;

  logic skip_exempt;

  always_comb begin
    f    = ifields_t'(w0);
    ind  = f.low[IND_BIT];
    bo   = f.low[BO_BIT];
    cond = f.low[COND_W-1:0];
  end

  assign op_ok       = VALID_MASK[f.op];
  assign skip_exempt = (f.op == SKIP_OP) && (f.tag == '0);
  assign ind_eff     = f.fmt && ind && !skip_exempt;
endmodule

// File: rtl/idec_agen.sv
module idec_agen
  import idec_pkg::*;
#(
  parameter int NXR = 3
) (
  input  logic             fmt,
  input  logic [TAG_W-1:0] tag,
  input  logic [LOW_W-1:0] low,
  input  word_t            w1,
  input  word_t            ic,
  input  word_t            xr [NXR],
  output word_t            addr
);
  localparam int NBASE = NXR + 1;

  word_t bases [NBASE];
  word_t short_ea;
  word_t long_ea;
  word_t idx_add;

  assign bases[0] = ic;
  for (genvar g = 0; g < NXR; g++) begin : g_base
    assign bases[g+1] = xr[g];
  end

  always_comb begin
    short_ea = wrap_add(bases[tag], sext_low(low));
    idx_add  = (tag == '0) ? '0 : bases[tag];
    long_ea  = wrap_add(w1, idx_add);
    addr     = fmt ? long_ea : short_ea;
  end
endmodule

// File: rtl/idec_seq.sv
module idec_seq
  import idec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  ifields_t          f_in,
  input  logic              ind_in,
  input  logic              bo_in,
  input  logic [COND_W-1:0] cond_in,
  input  logic              op_ok,
  input  logic              ind_eff,
  input  word_t             addr_in,
  input  logic              rd_ack,
  input  word_t             rd_data,
  output ifields_t          f_q,
  output logic              ind_q,
  output logic              bo_q,
  output logic [COND_W-1:0] cond_q,
  output word_t             ea_q,
  output logic              done_q,
  output logic              bad_q,
  output logic              rd_req_q,
  output word_t             rd_addr_q,
  output logic              accept
);
  seq_st_t st;

  assign accept = start && (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      f_q       <= '0;
      ind_q     <= 1'b0;
      bo_q      <= 1'b0;
      cond_q    <= '0;
      ea_q      <= '0;
      done_q    <= 1'b0;
      bad_q     <= 1'b0;
      rd_req_q  <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      bad_q  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            f_q    <= f_in;
            ind_q  <= ind_in;
            bo_q   <= bo_in;
            cond_q <= cond_in;
            if (!op_ok) begin
              bad_q <= 1'b1;
            end else if (ind_eff) begin
              rd_req_q  <= 1'b1;
              rd_addr_q <= addr_in;
              st        <= ST_WAIT;
            end else begin
              ea_q   <= addr_in;
              done_q <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (rd_ack) begin
            ea_q     <= rd_data;
            done_q   <= 1'b1;
            rd_req_q <= 1'b0;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idec_top.sv
module idec_top
  import idec_pkg::*;
#(
  parameter logic [31:0]     VALID_MASK = 32'h7FFF_737E,
  parameter logic [OP_W-1:0] SKIP_OP    = 5'd14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [15:0]        instr_w0,
  input  logic [15:0]        instr_w1,
  input  logic [15:0]        ic_next,
  input  logic [15:0]        xr1,
  input  logic [15:0]        xr2,
  input  logic [15:0]        xr3,
  input  logic               rd_ack,
  input  logic [15:0]        rd_data,
  output logic [4:0]         op_code,
  output logic               fmt_long,
  output logic [1:0]         tag,
  output logic [7:0]         disp,
  output logic               ind_flag,
  output logic               bo_flag,
  output logic [5:0]         cond_sel,
  output logic [15:0]        ea,
  output logic               done,
  output logic               bad_op,
  output logic               rd_req,
  output logic [15:0]        rd_addr
);
  localparam int NXR = 3;

  ifields_t          dec_f;
  logic              dec_ind;
  logic              dec_bo;
  logic [COND_W-1:0] dec_cond;
  logic              dec_ok;
  logic              dec_ind_eff;
  word_t             gen_addr;
  word_t             xr_vec [NXR];
  ifields_t          f_q;
  logic              evt_accept;

  assign xr_vec[0] = xr1;
  assign xr_vec[1] = xr2;
  assign xr_vec[2] = xr3;

  idec_fields #(.VALID_MASK(VALID_MASK), .SKIP_OP(SKIP_OP)) u_fields (
    .w0(instr_w0), .f(dec_f), .ind(dec_ind), .bo(dec_bo),
    .cond(dec_cond), .op_ok(dec_ok), .ind_eff(dec_ind_eff)
  );

  idec_agen #(.NXR(NXR)) u_agen (
    .fmt(dec_f.fmt), .tag(dec_f.tag), .low(dec_f.low),
    .w1(instr_w1), .ic(ic_next), .xr(xr_vec), .addr(gen_addr)
  );

  idec_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .f_in(dec_f), .ind_in(dec_ind), .bo_in(dec_bo), .cond_in(dec_cond),
    .op_ok(dec_ok), .ind_eff(dec_ind_eff), .addr_in(gen_addr),
    .rd_ack(rd_ack), .rd_data(rd_data),
    .f_q(f_q), .ind_q(ind_flag), .bo_q(bo_flag), .cond_q(cond_sel),
    .ea_q(ea), .done_q(done), .bad_q(bad_op),
    .rd_req_q(rd_req), .rd_addr_q(rd_addr), .accept(evt_accept)
  );

  assign op_code  = f_q.op;
  assign fmt_long = f_q.fmt;
  assign tag      = f_q.tag;
  assign disp     = f_q.low;
endmodule

// File: rtl/idec_chk.sv
module idec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        rd_ack,
  input logic [15:0] rd_data,
  input logic        rd_req,
  input logic [15:0] rd_addr,
  input logic        done,
  input logic        bad_op,
  input logic [4:0]  op_code,
  input logic [15:0] ea,
  input logic        accept
);
  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R5
  rd_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack) |=> (done && !rd_req && ea == $past(rd_data)));

  // R7
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> (!done && !rd_req && $past(accept)));

  // R4
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(accept || (rd_req && rd_ack)));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && start) |=> ($stable(op_code) && $stable(rd_addr)));
endmodule

bind idec_top idec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_ack(rd_ack), .rd_data(rd_data),
  .rd_req(rd_req), .rd_addr(rd_addr), .done(done), .bad_op(bad_op),
  .op_code(op_code), .ea(ea), .accept(evt_accept)
);

// File: tb/sim_idec_top.sv
`timescale 1ns/1ps
module sim_idec_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr_w0 = '0, instr_w1 = '0, ic_next = '0;
  logic [15:0] xr1 = '0, xr2 = '0, xr3 = '0;
  logic        rd_ack = 1'b0;
  logic [15:0] rd_data = '0;
  logic [4:0]  op_code;
  logic        fmt_long, ind_flag, bo_flag, done, bad_op, rd_req;
  logic [1:0]  tag;
  logic [7:0]  disp;
  logic [5:0]  cond_sel;
  logic [15:0] ea, rd_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  idec_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .instr_w0(instr_w0),
    .instr_w1(instr_w1), .ic_next(ic_next), .xr1(xr1), .xr2(xr2), .xr3(xr3),
    .rd_ack(rd_ack), .rd_data(rd_data), .op_code(op_code), .fmt_long(fmt_long),
    .tag(tag), .disp(disp), .ind_flag(ind_flag), .bo_flag(bo_flag),
    .cond_sel(cond_sel), .ea(ea), .done(done), .bad_op(bad_op),
    .rd_req(rd_req), .rd_addr(rd_addr)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic bit model_valid(input logic [4:0] op);
    case (op)
      5'd0, 5'd7, 5'd10, 5'd11, 5'd15, 5'd31: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] model_addr(input logic [15:0] w0, input logic [15:0] w1,
                                             input logic [15:0] icv, input logic [15:0] a,
                                             input logic [15:0] b, input logic [15:0] c);
    int base, d;
    case (w0[9:8])
      2'd0: base = int'(icv);
      2'd1: base = int'(a);
      2'd2: base = int'(b);
      default: base = int'(c);
    endcase
    if (!w0[10]) begin
      d = int'(w0[7:0]);
      if (d >= 128) d = d - 256;
      return 16'((base + d + 65536) % 65536);
    end
    if (w0[9:8] == 2'd0) base = 0;
    return 16'((int'(w1) + base) % 65536);
  endfunction

  function automatic bit model_indirect(input logic [15:0] w0);
    if (!w0[10] || !w0[7]) return 1'b0;
    if (w0[15:11] == 5'd14 && w0[9:8] == 2'd0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic run_one(input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] icv,
                         input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                         input int stall, input bit poke);
    logic [15:0] exp_a, dat;
    @(negedge clk);
    instr_w0 = w0; instr_w1 = w1; ic_next = icv; xr1 = a; xr2 = b; xr3 = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp_a = model_addr(w0, w1, icv, a, b, c);
    // R1 field slicing
    check({op_code, fmt_long, tag, disp} == w0, "R1 fields", int'({op_code, fmt_long, tag, disp}), int'(w0));
    check({ind_flag, bo_flag, cond_sel} == w0[7:0], "R1 low bits", int'({ind_flag, bo_flag, cond_sel}), int'(w0[7:0]));
    if (!model_valid(w0[15:11])) begin
      check(bad_op && !done && !rd_req, "R7 invalid strobe", int'({bad_op, done, rd_req}), 4);
      @(negedge clk);
      check(!bad_op && !done && !rd_req, "R7 single cycle", int'({bad_op, done, rd_req}), 0);
    end else if (model_indirect(w0)) begin
      check(rd_req && !done, "R5 request raised", int'({rd_req, done}), 2);
      check(rd_addr == exp_a, "R5 R3 read address", int'(rd_addr), int'(exp_a));
      for (int k = 0; k < stall; k++) begin
        if (poke && k == 0) begin
          instr_w0 = ~w0; start = 1'b1;
          @(negedge clk);
          start = 1'b0;
          check(op_code == w0[15:11] && rd_addr == exp_a, "R8 start ignored",
                int'({op_code, rd_addr}), int'({w0[15:11], exp_a}));
        end else begin
          @(negedge clk);
        end
        check(rd_req && rd_addr == exp_a, "R5 request held", int'(rd_addr), int'(exp_a));
      end
      dat = 16'($urandom);
      rd_ack = 1'b1; rd_data = dat;
      @(negedge clk);
      rd_ack = 1'b0;
      check(done && !rd_req && ea == dat, "R5 indirect result", int'(ea), int'(dat));
      @(negedge clk);
      check(!done, "R5 done single cycle", int'(done), 0);
    end else begin
      // R2/R3/R6 direct result
      check(done && !rd_req && ea == exp_a, "R4 R2 R3 R6 direct ea", int'(ea), int'(exp_a));
      @(negedge clk);
      check(!done && !rd_req, "R4 done single cycle", int'({done, rd_req}), 0);
    end
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] w0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!done && !bad_op && !rd_req && ea == 16'h0, "R9 reset", int'({done, bad_op, rd_req, ea}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !bad_op && !rd_req, "R9 after release", int'({done, bad_op, rd_req}), 0);

    // R2 negative displacement wrapping below zero: 0x0010 - 128 = 0xFF90
    run_one({5'd24, 1'b0, 2'd0, 8'h80}, 16'h0, 16'h0010, 16'h0, 16'h0, 16'h0, 0, 0);
    // R2 positive displacement wrapping past 65535 on xr3
    run_one({5'd16, 1'b0, 2'd3, 8'h7F}, 16'h0, 16'h0, 16'h1, 16'h2, 16'hFFF0, 0, 0);
    // R3 index addition wrap
    run_one({5'd26, 1'b1, 2'd2, 8'h00}, 16'hFFFF, 16'h0, 16'h5, 16'h0002, 16'h7, 0, 0);
    // R3 tag 0 adds nothing
    run_one({5'd8, 1'b1, 2'd0, 8'h3F}, 16'h1234, 16'h9999, 16'h1, 16'h2, 16'h3, 0, 0);
    // R5 indirect with stall and a start during the wait (R8)
    run_one({5'd24, 1'b1, 2'd1, 8'h80}, 16'h4000, 16'h0, 16'h0100, 16'h0, 16'h0, 3, 1);
    // R6 skip op with tag 0: bit 7 ignored
    run_one({5'd14, 1'b1, 2'd0, 8'hC1}, 16'h0ABC, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0);
    // R6 contrast: skip op with tag 1 stays indirect
    run_one({5'd14, 1'b1, 2'd1, 8'h80}, 16'h0ABC, 16'h0, 16'h0004, 16'h0, 16'h0, 1, 0);
    // R7 every invalid code
    run_one({5'd0,  1'b0, 2'd0, 8'h01}, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0);
    run_one({5'd7,  1'b1, 2'd1, 8'h80}, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0);
    run_one({5'd10, 1'b0, 2'd2, 8'h11}, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0);
    run_one({5'd11, 1'b1, 2'd3, 8'hFF}, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0);
    run_one({5'd15, 1'b1, 2'd0, 8'h80}, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0);
    run_one({5'd31, 1'b0, 2'd1, 8'h00}, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0);

    for (int i = 0; i < 400; i++) begin
      w0 = 16'($urandom);
      if (i % 7 == 0) w0[15:11] = 5'd14;
      run_one(w0, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
              int'($urandom % 4), bit'($urandom % 2));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule